// File: doc/BRIEF.md
# Tape Controller Register Interface

This block is the bus-facing register file of a tape controller that serves up to eight drives. A host reaches six 16-bit locations through a small word/byte slave port. The locations are a status word, a command word, a byte/record counter, a memory address, an 8-bit data buffer and a read-lines word. The block owns the command word and its DONE, ERR and interrupt-request semantics. It builds the status word from error bits it latches and from the live flags of the drive that the command's unit field selects.

A write that carries the GO bit issues a one-cycle start pulse to the transfer engine. That engine lives outside this block and reports back with a completion strobe and an error mask. A command write that arrives while the controller is busy is refused and flagged as illegal. A write that carries the init bit returns the whole block to its reset state.

Top module: `tape_regfile`

## Requirements
- R1: The register is chosen by `bus_addr[3:1]`: 0 status, 1 command, 2 counter, 3 address, 4 data buffer, 5 read lines. Indices 6 and 7 read as 0. After reset the command word reads 0x0080 (DONE only), and the counter, address and data buffer read 0.
- R2: For the command, counter and address registers, a byte write (`bus_byte`=1) takes its byte from `bus_wdata[7:0]`. With `bus_addr[0]`=1 it replaces bits 15:8, and with `bus_addr[0]`=0 it replaces bits 7:0. The other byte keeps its value. A word write replaces all 16 bits.
- R3: The data buffer holds 8 bits and reads back zero-extended. A byte write to its odd address changes nothing.
- R4: A command write while DONE (command bit 7) is 0 leaves the command word unchanged, sets status bit 15 (illegal), and starts nothing.
- R5: An accepted command write whose merged value has bit 12 set resets the block. The command word becomes 0x0080, the other registers and latched errors become 0, the read-lines word becomes 0, and the interrupt request drops.
- R6: Only command bits 14:13, 11:8, 6 and 5:1 (mask 0x6F7E) are stored from a write. Bit 0 (GO), bit 7 (DONE), bit 12 and bit 15 (ERR) are never written directly.
- R7: An accepted write with bit 0 set raises `start_pulse` for exactly one cycle, clears DONE, clears latched errors and drops the interrupt request. If the drive named by the new unit field (bits 10:8) is busy, the write instead sets status bit 15, keeps DONE set and issues no pulse.
- R8: An accepted write that turns interrupt enable (bit 6) from 0 to 1 while ERR or DONE is set raises `irq_req`. A write with bit 6 clear drops `irq_req`.
- R9: An `eng_done` strobe sets DONE and ORs `eng_err` into the latched error bits 15, 13, 12, 11, 9, 8 and 7. It also raises `irq_req` when interrupt enable is set.
- R10: Each read of index 5 returns the stored word with bit 15 inverted, and that inverted value is stored. The first read after reset gives 0x8000 and the next gives 0x0000.
- R11: The status word is made up as follows. Bits 15, 13, 12, 11, 9, 8 and 7 come from the latched errors. The selected drive supplies bit 14 (file mark), bit 10 (end of tape), bit 6 (online), bit 5 (load point), bit 2 (write locked) and bit 1 (rewinding). Bit 0 is 1 when that drive is idle, and bits 4:3 are 0. ERR (`ctl_err`, command bit 15 on read) is the OR of status bits 15, 14, 13, 12, 11, 9, 8 and 7.
- R12: Writes to the status and read-lines indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte access when 1 |
| bus_addr | input | 4 | Bits 3:1 register index, bit 0 byte lane |
| bus_wdata | input | 16 | Write data (byte data on bits 7:0) |
| bus_rdata | output | 16 | Read data for the addressed register |
| drv_busy | input | NUM_DRIVES | Per-drive busy |
| drv_online | input | NUM_DRIVES | Per-drive online |
| drv_bot | input | NUM_DRIVES | Per-drive at load point |
| drv_wlock | input | NUM_DRIVES | Per-drive write locked |
| drv_rewind | input | NUM_DRIVES | Per-drive rewinding |
| drv_eof | input | NUM_DRIVES | Per-drive file mark seen |
| drv_eot | input | NUM_DRIVES | Per-drive end of tape |
| eng_done | input | 1 | Transfer engine completion strobe |
| eng_err | input | 16 | Error bits reported with completion |
| ctl_err | output | 1 | Live ERR flag |
| ctl_done | output | 1 | DONE flag |
| irq_req | output | 1 | Interrupt request |
| start_pulse | output | 1 | One-cycle engine start |

## Verification
The properties assume that `eng_done` never coincides with a bus write to the command word, and that the engine reports completion only after it has been started. Otherwise a completion could set DONE in the same cycle a GO clears it. They also assume each bus access lasts one cycle. The stimulus drives every access and every strobe as a single-cycle pulse on a falling edge and issues at most one of them per cycle. It raises `eng_done` only while DONE is clear, or as a deliberate stray completion with no bus traffic in that cycle.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;

    localparam int WORD_W = 16;

    typedef logic [2:0] reg_idx_t;

    localparam reg_idx_t IDX_STAT = 3'd0;
    localparam reg_idx_t IDX_CMD  = 3'd1;
    localparam reg_idx_t IDX_BCNT = 3'd2;
    localparam reg_idx_t IDX_MADR = 3'd3;
    localparam reg_idx_t IDX_DBUF = 3'd4;
    localparam reg_idx_t IDX_RLIN = 3'd5;

    // command word bit positions
    localparam int CB_GO   = 0;
    localparam int CB_IE   = 6;
    localparam int CB_DONE = 7;
    localparam int CB_UNIT = 8;
    localparam int CB_INIT = 12;
    localparam int CB_ERR  = 15;
    localparam int UNIT_W  = 3;

    localparam logic [WORD_W-1:0] CMD_WMASK  = 16'h6F7E;
    localparam logic [WORD_W-1:0] CMD_RESET  = 16'h0080;

    // status word
    localparam int SB_ILL = 15;
    localparam logic [WORD_W-1:0] LATCH_MASK = 16'hBB80;
    localparam logic [WORD_W-1:0] EFLAG_MASK = 16'hFB80;
    localparam int RL_TICK = 15;

    typedef struct packed {
        logic eof;
        logic eot;
        logic online;
        logic bot;
        logic wlock;
        logic rewind;
        logic busy;
    } drive_flags_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] wr_v,
        input logic              is_byte,
        input logic              hi_lane
    );
        logic [WORD_W-1:0] r;
        if (!is_byte)     r = wr_v;
        else if (hi_lane) r = {wr_v[7:0], old_v[7:0]};
        else              r = {old_v[15:8], wr_v[7:0]};
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(
        input logic [WORD_W-1:0] latched,
        input drive_flags_t      d
    );
        logic [WORD_W-1:0] s;
        s      = latched & LATCH_MASK;
        s[14]  = d.eof;
        s[10]  = d.eot;
        s[6]   = d.online;
        s[5]   = d.bot;
        s[2]   = d.wlock;
        s[1]   = d.rewind;
        s[0]   = ~d.busy;
        return s;
    endfunction

endpackage

// File: rtl/tape_drive_mux.sv
module tape_drive_mux
    import tape_regs_pkg::*;
#(
    parameter int NUM_DRIVES = 8
) (
    input  drive_flags_t [NUM_DRIVES-1:0] flags,
    input  logic [UNIT_W-1:0]             unit,
    output drive_flags_t                  sel
);
    localparam int SPAN = 1 << UNIT_W;

    drive_flags_t [SPAN-1:0] padded;

    for (genvar i = 0; i < SPAN; i++) begin : g_pad
        if (i < NUM_DRIVES) begin : g_real
            assign padded[i] = flags[i];
        end else begin : g_empty
            assign padded[i] = '0;
        end
    end

    assign sel = padded[unit];
endmodule

// File: rtl/tape_status_build.sv
module tape_status_build
    import tape_regs_pkg::*;
(
    input  logic [WORD_W-1:0] latched,
    input  drive_flags_t      drive,
    output logic [WORD_W-1:0] status,
    output logic              err
);
    always_comb begin
        status = status_word(latched, drive);
        err    = |(status & EFLAG_MASK);
    end
endmodule

// File: rtl/tape_ctl_core.sv
module tape_ctl_core
    import tape_regs_pkg::*;
#(
    parameter int NUM_DRIVES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_rd,
    input  logic                  acc_wr,
    input  logic                  acc_byte,
    input  logic                  acc_hi,
    input  reg_idx_t              acc_idx,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [NUM_DRIVES-1:0] drv_busy,
    input  logic                  cur_err,
    input  logic                  eng_done,
    input  logic [WORD_W-1:0]     eng_err,
    output logic [WORD_W-1:0]     cmd_q,
    output logic [WORD_W-1:0]     bcnt_q,
    output logic [WORD_W-1:0]     madr_q,
    output logic [7:0]            dbuf_q,
    output logic [WORD_W-1:0]     rlin_q,
    output logic [WORD_W-1:0]     latch_q,
    output logic                  irq_q,
    output logic                  start_q
);
    localparam int SPAN = 1 << UNIT_W;

    logic [SPAN-1:0]   busy_ext;
    logic [WORD_W-1:0] cmd_d, bcnt_d, madr_d, rlin_d, latch_d;
    logic [WORD_W-1:0] cmd_m, bcnt_m, madr_m;
    logic [7:0]        dbuf_d;
    logic              irq_d, start_d, init_hit, cmd_wr_ok;

    assign busy_ext = SPAN'(drv_busy);

    always_comb begin
        cmd_m  = merge_bytes(cmd_q,  wdata, acc_byte, acc_hi);
        bcnt_m = merge_bytes(bcnt_q, wdata, acc_byte, acc_hi);
        madr_m = merge_bytes(madr_q, wdata, acc_byte, acc_hi);
        cmd_wr_ok = acc_wr && (acc_idx == IDX_CMD) && cmd_q[CB_DONE];
        init_hit  = cmd_wr_ok && cmd_m[CB_INIT];
    end

    always_comb begin
        cmd_d   = cmd_q;
        bcnt_d  = bcnt_q;
        madr_d  = madr_q;
        dbuf_d  = dbuf_q;
        rlin_d  = rlin_q;
        latch_d = latch_q;
        irq_d   = irq_q;
        start_d = 1'b0;

        if (eng_done) begin
            cmd_d[CB_DONE] = 1'b1;
            latch_d        = latch_q | (eng_err & LATCH_MASK);
            if (cmd_q[CB_IE]) irq_d = 1'b1;
        end

        if (acc_rd && acc_idx == IDX_RLIN)
            rlin_d[RL_TICK] = ~rlin_q[RL_TICK];

        if (acc_wr) begin
            case (acc_idx)
                IDX_CMD: begin
                    if (!cmd_q[CB_DONE]) begin
                        latch_d[SB_ILL] = 1'b1;
                    end else begin
                        cmd_d = (cmd_q & ~CMD_WMASK) | (cmd_m & CMD_WMASK);
                        if (!cmd_m[CB_IE])
                            irq_d = 1'b0;
                        else if (!cmd_q[CB_IE] && (cur_err || cmd_q[CB_DONE]))
                            irq_d = 1'b1;
                        if (cmd_m[CB_GO]) begin
                            if (busy_ext[cmd_m[CB_UNIT +: UNIT_W]]) begin
                                latch_d[SB_ILL] = 1'b1;
                            end else begin
                                start_d        = 1'b1;
                                cmd_d[CB_DONE] = 1'b0;
                                latch_d        = '0;
                                irq_d          = 1'b0;
                            end
                        end
                    end
                end
                IDX_BCNT: bcnt_d = bcnt_m;
                IDX_MADR: madr_d = madr_m;
                IDX_DBUF: if (!(acc_byte && acc_hi)) dbuf_d = wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_hit) begin
            cmd_q   <= CMD_RESET;
            bcnt_q  <= '0;
            madr_q  <= '0;
            dbuf_q  <= '0;
            rlin_q  <= '0;
            latch_q <= '0;
            irq_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            cmd_q   <= cmd_d;
            bcnt_q  <= bcnt_d;
            madr_q  <= madr_d;
            dbuf_q  <= dbuf_d;
            rlin_q  <= rlin_d;
            latch_q <= latch_d;
            irq_q   <= irq_d;
            start_q <= start_d;
        end
    end
endmodule

// File: rtl/tape_regfile.sv
module tape_regfile
    import tape_regs_pkg::*;
#(
    parameter int NUM_DRIVES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_byte,
    input  logic [3:0]            bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    input  logic [NUM_DRIVES-1:0] drv_busy,
    input  logic [NUM_DRIVES-1:0] drv_online,
    input  logic [NUM_DRIVES-1:0] drv_bot,
    input  logic [NUM_DRIVES-1:0] drv_wlock,
    input  logic [NUM_DRIVES-1:0] drv_rewind,
    input  logic [NUM_DRIVES-1:0] drv_eof,
    input  logic [NUM_DRIVES-1:0] drv_eot,
    input  logic                  eng_done,
    input  logic [15:0]           eng_err,
    output logic                  ctl_err,
    output logic                  ctl_done,
    output logic                  irq_req,
    output logic                  start_pulse
);
    drive_flags_t [NUM_DRIVES-1:0] flags;
    drive_flags_t                  cur_drive;
    reg_idx_t                      idx;
    logic [WORD_W-1:0] cmd_q, bcnt_q, madr_q, rlin_q, latch_q, status, cmd_word;
    logic [7:0]        dbuf_q;
    logic              err;

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_pack
        assign flags[i] = '{eof: drv_eof[i], eot: drv_eot[i], online: drv_online[i],
                            bot: drv_bot[i], wlock: drv_wlock[i],
                            rewind: drv_rewind[i], busy: drv_busy[i]};
    end

    assign idx = bus_addr[3:1];

    tape_ctl_core #(.NUM_DRIVES(NUM_DRIVES)) u_core (
        .clk      (clk),
        .rst      (rst),
        .acc_rd   (bus_valid && !bus_write),
        .acc_wr   (bus_valid && bus_write),
        .acc_byte (bus_byte),
        .acc_hi   (bus_addr[0]),
        .acc_idx  (idx),
        .wdata    (bus_wdata),
        .drv_busy (drv_busy),
        .cur_err  (err),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .cmd_q    (cmd_q),
        .bcnt_q   (bcnt_q),
        .madr_q   (madr_q),
        .dbuf_q   (dbuf_q),
        .rlin_q   (rlin_q),
        .latch_q  (latch_q),
        .irq_q    (irq_req),
        .start_q  (start_pulse)
    );

    tape_drive_mux #(.NUM_DRIVES(NUM_DRIVES)) u_mux (
        .flags (flags),
        .unit  (cmd_q[CB_UNIT +: UNIT_W]),
        .sel   (cur_drive)
    );

    tape_status_build u_stat (
        .latched (latch_q),
        .drive   (cur_drive),
        .status  (status),
        .err     (err)
    );

    assign cmd_word = {err, cmd_q[CB_ERR-1:0]};
    assign ctl_err  = err;
    assign ctl_done = cmd_q[CB_DONE];

    always_comb begin
        case (idx)
            IDX_STAT: bus_rdata = status;
            IDX_CMD:  bus_rdata = cmd_word;
            IDX_BCNT: bus_rdata = bcnt_q;
            IDX_MADR: bus_rdata = madr_q;
            IDX_DBUF: bus_rdata = {8'h00, dbuf_q};
            IDX_RLIN: bus_rdata = {~rlin_q[RL_TICK], rlin_q[RL_TICK-1:0]};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

module tape_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic        bus_byte,
    input logic [3:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] cmd_word,
    input logic        ctl_err,
    input logic        ctl_done,
    input logic        irq_req,
    input logic        start_pulse,
    input logic        eng_done
);
    logic cmd_wr;
    assign cmd_wr = bus_valid && bus_write && (bus_addr[3:1] == 3'd1);

    // R7: the start strobe never lasts more than one cycle
    a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R7: when the start strobe is high, DONE has been cleared
    a_r7_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !ctl_done);

    // R4: a command write while busy is refused and flags an error
    a_r4_busy_refused: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !ctl_done && !eng_done) |=> (ctl_err && !start_pulse && !ctl_done));

    // R8: a pending request requires interrupt enable
    a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> cmd_word[6]);

    // R5: an accepted word write with the init bit restores the idle state
    a_r5_init_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && ctl_done && !bus_byte && bus_wdata[12]) |=>
        (ctl_done && !irq_req && !start_pulse && (cmd_word[14:0] == 15'h0080)));

    // R9: completion sets DONE
    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !cmd_wr) |=> ctl_done);
endmodule

bind tape_regfile tape_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_byte    (bus_byte),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cmd_word    (cmd_word),
    .ctl_err     (ctl_err),
    .ctl_done    (ctl_done),
    .irq_req     (irq_req),
    .start_pulse (start_pulse),
    .eng_done    (eng_done)
);

// File: tb/tb_tape_regfile.sv
`timescale 1ns/1ps
module tb_tape_regfile;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_byte = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [ND-1:0] drv_busy = '0, drv_online = '0, drv_bot = '0, drv_wlock = '0;
    logic [ND-1:0] drv_rewind = '0, drv_eof = '0, drv_eot = '0;
    logic        eng_done = 1'b0;
    logic [15:0] eng_err = '0;
    logic        ctl_err, ctl_done, irq_req, start_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tape_regfile #(.NUM_DRIVES(ND)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .drv_busy(drv_busy), .drv_online(drv_online),
        .drv_bot(drv_bot), .drv_wlock(drv_wlock), .drv_rewind(drv_rewind),
        .drv_eof(drv_eof), .drv_eot(drv_eot), .eng_done(eng_done),
        .eng_err(eng_err), .ctl_err(ctl_err), .ctl_done(ctl_done),
        .irq_req(irq_req), .start_pulse(start_pulse)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic byt);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic done_strobe(input logic [15:0] e);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e;
        @(posedge clk); #1;
        eng_done = 1'b0; eng_err = '0;
    endtask

    function automatic logic [15:0] exp_status(input int i);
        logic [15:0] s;
        s = '0;
        s[14] = (i == 3);
        s[10] = (i == 5);
        s[6]  = i[0];
        s[5]  = i[1];
        s[2]  = i[2];
        s[1]  = ~i[0];
        s[0]  = (i != 6);
        return s;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state and decode
        rdchk("R1 cmd reset", 4'h2, 16'h0080);
        rdchk("R1 status reset", 4'h0, 16'h0001);
        rdchk("R1 bcnt reset", 4'h4, 16'h0000);
        rdchk("R1 madr reset", 4'h6, 16'h0000);
        rdchk("R1 dbuf reset", 4'h8, 16'h0000);
        rdchk("R1 idx6 zero", 4'hC, 16'h0000);
        rdchk("R1 idx7 zero", 4'hE, 16'h0000);

        // R1 word writes and R2 byte merge sweep
        wr(4'h4, 16'h1234, 1'b0);
        rdchk("R1 bcnt word", 4'h4, 16'h1234);
        for (int b = 0; b < 256; b += 17) begin
            wr(4'h4, 16'(b), 1'b1);
            rdchk("R2 bcnt low byte", 4'h4, {8'h12, 8'(b)});
            wr(4'h7, 16'hFF00 | 16'(255 - b), 1'b1);
            rdchk("R2 madr high byte", 4'h6, {8'(255 - b), 8'h00});
        end
        wr(4'h5, 16'h0055, 1'b1);
        rdchk("R2 bcnt high byte", 4'h4, 16'h55FF);

        // R3 data buffer
        wr(4'h8, 16'h1FF5, 1'b0);
        rdchk("R3 dbuf 8 bit", 4'h8, 16'h00F5);
        wr(4'h9, 16'h0033, 1'b1);
        rdchk("R3 dbuf odd byte ignored", 4'h8, 16'h00F5);
        wr(4'h8, 16'h0077, 1'b1);
        rdchk("R3 dbuf even byte", 4'h8, 16'h0077);

        // R6 writable mask, R8 IE rising with DONE
        wr(4'h2, 16'hEFFE, 1'b0);
        rdchk("R6 cmd mask", 4'h2, 16'h6FFE);
        check("R8 irq on IE rise", 16'(irq_req), 16'h1);
        wr(4'h2, 16'h0000, 1'b0);
        check("R8 irq dropped", 16'(irq_req), 16'h0);
        rdchk("R6 cmd cleared", 4'h2, 16'h0080);
        wr(4'h3, 16'h0007, 1'b1);
        rdchk("R2 cmd high byte", 4'h2, 16'h0780);
        wr(4'h2, 16'h000C, 1'b1);
        rdchk("R2 cmd low byte", 4'h2, 16'h078C);

        // R11 status composition sweep over all units
        for (int i = 0; i < ND; i++) begin
            drv_online[i] = i[0]; drv_bot[i] = i[1]; drv_wlock[i] = i[2];
            drv_rewind[i] = ~i[0]; drv_eof[i] = (i == 3); drv_eot[i] = (i == 5);
            drv_busy[i] = (i == 6);
        end
        for (int u = 0; u < ND; u++) begin
            wr(4'h2, 16'(u) << 8, 1'b0);
            rdchk("R11 status", 4'h0, exp_status(u));
            check("R11 err", 16'(ctl_err), 16'(u == 3));
        end
        drv_online = '0; drv_bot = '0; drv_wlock = '0; drv_rewind = '0;
        drv_eof = '0; drv_eot = '0; drv_busy = '0;

        // R7 start pulse
        wr(4'h2, 16'h0003, 1'b0);
        check("R7 start high", 16'(start_pulse), 16'h1);
        check("R7 done cleared", 16'(ctl_done), 16'h0);
        @(posedge clk); #1;
        check("R7 start one cycle", 16'(start_pulse), 16'h0);

        // R4 refused while busy
        wr(4'h2, 16'h0041, 1'b0);
        check("R4 no start", 16'(start_pulse), 16'h0);
        rdchk("R4 cmd unchanged", 4'h2, 16'h8002);
        rdchk("R4 status ill", 4'h0, 16'h8001);

        // R9 completion
        done_strobe(16'h1000);
        rdchk("R9 status errors", 4'h0, 16'h9001);
        rdchk("R9 cmd done", 4'h2, 16'h8082);
        check("R9 no irq without IE", 16'(irq_req), 16'h0);
        wr(4'h2, 16'h0040, 1'b0);
        check("R8 irq on IE with done", 16'(irq_req), 16'h1);
        wr(4'h2, 16'h0043, 1'b0);
        check("R7 start again", 16'(start_pulse), 16'h1);
        check("R7 irq cleared", 16'(irq_req), 16'h0);
        rdchk("R7 errors cleared", 4'h2, 16'h0042);
        done_strobe(16'h0000);
        check("R9 irq with IE", 16'(irq_req), 16'h1);
        rdchk("R9 cmd after done", 4'h2, 16'h00C2);

        // R7 busy selected drive
        drv_busy[6] = 1'b1;
        wr(4'h2, 16'h0603, 1'b0);
        check("R7 busy no start", 16'(start_pulse), 16'h0);
        check("R7 busy keeps done", 16'(ctl_done), 16'h1);
        rdchk("R7 busy cmd", 4'h2, 16'h8682);
        rdchk("R7 busy status", 4'h0, 16'h8000);
        drv_busy = '0;

        // R10 read lines
        rdchk("R10 first read", 4'hA, 16'h8000);
        rdchk("R10 second read", 4'hA, 16'h0000);
        rdchk("R10 third read", 4'hA, 16'h8000);

        // R12 writes to read-only indices
        wr(4'h0, 16'hFFFF, 1'b0);
        rdchk("R12 status unchanged", 4'h0, 16'h8001 & 16'h8001);
        wr(4'hA, 16'h7FFF, 1'b0);
        rdchk("R12 rlin unchanged", 4'hA, 16'h0000);

        // R5 init
        wr(4'h2, 16'h0040, 1'b0);
        wr(4'h2, 16'h1040, 1'b0);
        check("R5 irq cleared", 16'(irq_req), 16'h0);
        rdchk("R5 cmd", 4'h2, 16'h0080);
        rdchk("R5 status", 4'h0, 16'h0001);
        rdchk("R5 bcnt", 4'h4, 16'h0000);
        rdchk("R5 madr", 4'h6, 16'h0000);
        rdchk("R5 dbuf", 4'h8, 16'h0000);
        rdchk("R5 rlin", 4'hA, 16'h8000);

        rd(4'h0, v);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule